// File: doc/BRIEF.md
# Dual-Carry Fracturable Logic Element

This block is a behavioural model of one adaptive logic element for a programmable fabric, aimed at dense low-precision multiply-accumulate mapping. A flat configuration word is captured while a load strobe is high. Once loaded, the element maps its eight shared data inputs to four outputs in one of three ways. It can act as a single 6-input lookup table. It can act as two 5-input lookup tables that share two inputs. Or it can act as an arithmetic element, where four 4-input table fragments build adder operands for a ripple carry chain.

Two optional features extend the arithmetic mode. The first is a second carry chain. It adds the first chain's sum bits to two raw inputs, so a second level of addition needs no table fragments spent as pass-through buffers. The second is a split mode. Each 4-input fragment becomes two 3-input fragments, which lets one element form eight operand bits and perform a 4-bit addition. Each chain's carry-in can come from its port or from a configured constant, which is how the head element of a column is seeded. Each output can be taken straight from the logic or through a flip-flop. The flip-flops share one clock and one synchronous clear.

Top module: `dual_carry_le`

## Requirements
- R1: The configuration word is captured on each rising clock edge at which `cfg_en_i` is high, and the new value takes effect after that edge. Reset clears it to all zero. With an all-zero configuration every data output is 0.
- R2: When `mode` is 0 (6-input table), or 3, `out_o[0]` equals `mask[in_i[5:0]]` and `out_o[3:1]` are 0.
- R3: When `mode` is 1 (dual 5-input table):
  - `out_o[0]` equals `mask[in_i[4:0]]`.
  - `out_o[1]` equals `mask[32 + {in_i[7:5], in_i[1:0]}]`.
  - `out_o[3:2]` are 0.
- R4: When `mode` is 2 with both new feature bits clear:
  - Quarter k is `mask[16k+15:16k]`, and `op_k = quarter_k[in_i[3:0]]`.
  - Operands are a = {op2, op0} and b = {op3, op1}.
  - `out_o[1:0]` is the 2-bit sum a + b + carry-in of chain 1, and `cout1_o` is its carry.
  - `out_o[3:2]` are 0, and `cout2_o` equals the chain-2 carry-in.
- R5: When `mode` is 2 with `xcc` set and `add4` clear:
  - `out_o[1:0]` is the first-chain sum as in R4.
  - `out_o[3:2]` is the 2-bit sum of the first-chain sum, `in_i[5:4]` and the chain-2 carry-in.
  - `cout2_o` is that second sum's carry.
- R6: When `mode` is 2 with `add4` set:
  - Bit k of operand a is `quarter_k[in_i[2:0]]`, and bit k of operand b is `quarter_k[8 + in_i[2:0]]`.
  - `out_o[3:0]` is the 4-bit sum a + b + chain-1 carry-in, and `cout1_o` is its carry.
  - `xcc` has no effect, and `cout2_o` equals the chain-2 carry-in.
- R7: For each chain, when its `use_const` bit is set, the chain's carry-in is the configured constant bit and the port value is ignored. Otherwise the carry-in is the port.
- R8: When `reg_en[k]` is set, `out_o[k]` shows the value that output's logic had at the last rising edge. When it is clear, `out_o[k]` follows the logic with no delay.
- R9: With `sclr_i` high at a rising edge, every registered output reads 0 after that edge. Combinational outputs are unaffected.
- R10: Outside mode 2, `xcc` and `add4` have no effect. In those modes `cout1_o` and `cout2_o` repeat their chains' effective carry-ins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for configuration and output registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Configuration capture strobe |
| cfg_i | input | 76 | Flat configuration word: {reg_en[3:0], cin2{use_const,val}, cin1{use_const,val}, add4, xcc, mode[1:0], mask[63:0]} from MSB down |
| sclr_i | input | 1 | Synchronous clear of the output registers |
| in_i | input | 8 | Shared data inputs |
| cin1_i | input | 1 | First-chain carry-in from the previous element |
| cin2_i | input | 1 | Second-chain carry-in from the previous element |
| out_o | output | 4 | Data outputs |
| cout1_o | output | 1 | First-chain carry-out |
| cout2_o | output | 1 | Second-chain carry-out |

## Verification
The assertions assume that `out_o`, the carry outputs and the configuration register are sampled only at rising edges. They also assume that the configuration word is stable between loads. Loads are allowed to coincide with data activity, because the register checks compare against the previous cycle's logic value and the clear forces every flop to zero. The stimulus changes data inputs and strobes only at falling edges. It keeps `cfg_en_i` low while any data result is being checked, so each result comes from one settled configuration.

// File: rtl/dcle_pkg.sv
package dcle_pkg;
  localparam int unsigned NUM_IN  = 8;
  localparam int unsigned NUM_OUT = 4;
  localparam int unsigned LUT_K   = 6;
  localparam int unsigned MASK_W  = 1 << LUT_K;
  localparam int unsigned NUM_QTR = 4;
  localparam int unsigned QTR_W   = MASK_W / NUM_QTR;
  localparam int unsigned ADD_W   = NUM_QTR;
  localparam int unsigned BASE_W  = 2;

  typedef enum logic [1:0] {
    MODE_L6    = 2'd0,
    MODE_L5    = 2'd1,
    MODE_ARITH = 2'd2
  } lut_mode_e;

  typedef struct packed {
    logic use_const;
    logic val;
  } cin_cfg_t;

  typedef struct packed {
    logic [NUM_OUT-1:0] reg_en;
    cin_cfg_t           cin2;
    cin_cfg_t           cin1;
    logic               add4;
    logic               xcc;
    lut_mode_e          mode;
    logic [MASK_W-1:0]  mask;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/dcle_lut_fabric.sv
module dcle_lut_fabric
  import dcle_pkg::*;
(
  input  logic [MASK_W-1:0]  mask_i,
  input  logic [NUM_IN-1:0]  in_i,
  output logic               f6_o,
  output logic               f5a_o,
  output logic               f5b_o,
  output logic [BASE_W-1:0]  base_a_o,
  output logic [BASE_W-1:0]  base_b_o,
  output logic [ADD_W-1:0]   split_a_o,
  output logic [ADD_W-1:0]   split_b_o
);
  localparam int unsigned QIDX_W = $clog2(QTR_W);

  logic [NUM_QTR-1:0] op4;

  always_comb begin
    f6_o  = mask_i[in_i[LUT_K-1:0]];
    f5a_o = mask_i[{1'b0, in_i[4:0]}];
    // second half shares in[1:0] with the first half
    f5b_o = mask_i[{1'b1, in_i[7:5], in_i[1:0]}];
  end

  for (genvar k = 0; k < NUM_QTR; k++) begin : g_qtr
    logic [QTR_W-1:0] qtr;
    assign qtr          = mask_i[k*QTR_W +: QTR_W];
    assign op4[k]       = qtr[in_i[QIDX_W-1:0]];
    assign split_a_o[k] = qtr[{1'b0, in_i[QIDX_W-2:0]}];
    assign split_b_o[k] = qtr[{1'b1, in_i[QIDX_W-2:0]}];
  end

  assign base_a_o = {op4[2], op4[0]};
  assign base_b_o = {op4[3], op4[1]};
endmodule

// File: rtl/dcle_ripple.sv
module dcle_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = c[W];

  always_comb begin
    AST_RIPPLE_EXACT: assert ({cout_o, sum_o} ==
      ((W+1)'(a_i) + (W+1)'(b_i) + (W+1)'(cin_i))); // R4
  end
endmodule

// File: rtl/dcle_outreg.sv
module dcle_outreg
  import dcle_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclr_i,
  input  logic [NUM_OUT-1:0] reg_en_i,
  input  logic [NUM_OUT-1:0] d_i,
  output logic [NUM_OUT-1:0] out_o
);
  logic [NUM_OUT-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (sclr_i) q <= '0;
    else             q <= d_i;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_sel
    assign out_o[k] = reg_en_i[k] ? q[k] : d_i[k];
  end

  AST_SCLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclr_i |=> ((out_o & reg_en_i) == '0)); // R9
  AST_REG_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclr_i |=> ((out_o & reg_en_i) == ($past(d_i) & reg_en_i))); // R8
endmodule

// File: rtl/dual_carry_le.sv
module dual_carry_le
  import dcle_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_en_i,
  input  logic [CFG_W-1:0]   cfg_i,
  input  logic               sclr_i,
  input  logic [NUM_IN-1:0]  in_i,
  input  logic               cin1_i,
  input  logic               cin2_i,
  output logic [NUM_OUT-1:0] out_o,
  output logic               cout1_o,
  output logic               cout2_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_en_i) cfg_q <= cfg_t'(cfg_i);
  end

  logic cin1_eff, cin2_eff;
  assign cin1_eff = cfg_q.cin1.use_const ? cfg_q.cin1.val : cin1_i;
  assign cin2_eff = cfg_q.cin2.use_const ? cfg_q.cin2.val : cin2_i;

  logic              f6, f5a, f5b;
  logic [BASE_W-1:0] base_a, base_b;
  logic [ADD_W-1:0]  split_a, split_b;

  dcle_lut_fabric u_lut (
    .mask_i    (cfg_q.mask),
    .in_i      (in_i),
    .f6_o      (f6),
    .f5a_o     (f5a),
    .f5b_o     (f5b),
    .base_a_o  (base_a),
    .base_b_o  (base_b),
    .split_a_o (split_a),
    .split_b_o (split_b)
  );

  // level 1: operands zero-extended in base mode, so sum1[BASE_W] is its carry
  logic [ADD_W-1:0] l1_a, l1_b, sum1;
  logic             c1_full;
  assign l1_a = cfg_q.add4 ? split_a : {{(ADD_W-BASE_W){1'b0}}, base_a};
  assign l1_b = cfg_q.add4 ? split_b : {{(ADD_W-BASE_W){1'b0}}, base_b};

  dcle_ripple #(.W(ADD_W)) u_chain1 (
    .a_i    (l1_a),
    .b_i    (l1_b),
    .cin_i  (cin1_eff),
    .sum_o  (sum1),
    .cout_o (c1_full)
  );

  // level 2: adds first-level sum to raw inputs, no LUT in between
  logic [BASE_W-1:0] sum2;
  logic              c2_full;

  dcle_ripple #(.W(BASE_W)) u_chain2 (
    .a_i    (sum1[BASE_W-1:0]),
    .b_i    (in_i[5:4]),
    .cin_i  (cin2_eff),
    .sum_o  (sum2),
    .cout_o (c2_full)
  );

  logic               is_arith, l2_live;
  logic [NUM_OUT-1:0] comb_out;
  assign is_arith = (cfg_q.mode == MODE_ARITH);
  assign l2_live  = is_arith && cfg_q.xcc && !cfg_q.add4;

  always_comb begin
    case (cfg_q.mode)
      MODE_L5:    comb_out = {2'b00, f5b, f5a};
      MODE_ARITH: begin
        if (cfg_q.add4)     comb_out = sum1;
        else if (cfg_q.xcc) comb_out = {sum2, sum1[BASE_W-1:0]};
        else                comb_out = {2'b00, sum1[BASE_W-1:0]};
      end
      default:    comb_out = {3'b000, f6};
    endcase
  end

  assign cout1_o = !is_arith ? cin1_eff : (cfg_q.add4 ? c1_full : sum1[BASE_W]);
  assign cout2_o = l2_live ? c2_full : cin2_eff;

  dcle_outreg u_outreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclr_i   (sclr_i),
    .reg_en_i (cfg_q.reg_en),
    .d_i      (comb_out),
    .out_o    (out_o)
  );

  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> (cfg_q == cfg_t'($past(cfg_i)))); // R1
  AST_L6_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_L6 && cfg_q.reg_en == '0) |-> (out_o[3:1] == 3'b000)); // R2
  AST_SPLIT_L2_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_arith && cfg_q.add4) |->
      (cout2_o == (cfg_q.cin2.use_const ? cfg_q.cin2.val : cin2_i))); // R6
  AST_NONARITH_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_arith |-> (cout1_o == (cfg_q.cin1.use_const ? cfg_q.cin1.val : cin1_i))); // R10
endmodule

// File: tb/sim_dual_carry_le.sv
module sim_dual_carry_le;
  import dcle_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_en = 1'b0;
  logic [CFG_W-1:0] cfg = '0;
  logic             sclr = 1'b0;
  logic [7:0]       din = '0;
  logic             cin1 = 1'b0;
  logic             cin2 = 1'b0;
  logic [3:0]       dout;
  logic             cout1, cout2;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_carry_le u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_i(cfg), .sclr_i(sclr),
    .in_i(din), .cin1_i(cin1), .cin2_i(cin2),
    .out_o(dout), .cout1_o(cout1), .cout2_o(cout2)
  );

  function automatic cfg_t mk(logic [63:0] m, logic [1:0] md, logic x, logic a4,
                              logic u1, logic v1, logic u2, logic v2, logic [3:0] re);
    cfg_t c;
    c.mask = m; c.mode = lut_mode_e'(md); c.xcc = x; c.add4 = a4;
    c.cin1.use_const = u1; c.cin1.val = v1;
    c.cin2.use_const = u2; c.cin2.val = v2;
    c.reg_en = re;
    return c;
  endfunction

  // masks: M6 -> in0&in5; M5 -> A=in0, B=in7; MA -> a={in1,in0}, b={in3,in2};
  // M4 -> a={1,in2,in1,in0}, b={in2,0,1,1}
  localparam logic [63:0] M6 = 64'hAAAAAAAA_00000000;
  localparam logic [63:0] M5 = 64'hFFFF0000_AAAAAAAA;
  localparam logic [63:0] MA = 64'hFF00_CCCC_F0F0_AAAA;
  localparam logic [63:0] M4 = 64'hF0FF_00F0_FFCC_FFAA;

  typedef struct packed {
    cfg_t       c;
    logic [7:0] d;
    logic       ci1;
    logic       ci2;
    logic [3:0] eo;
    logic       ec1;
    logic       ec2;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{mk(M6,2'd0,0,0,0,0,0,0,4'h0), 8'h21, 0,0, 4'b0001, 0,0, 4'd2},  // R2
    '{mk(M6,2'd0,0,0,0,0,0,0,4'h0), 8'h20, 0,0, 4'b0000, 0,0, 4'd2},  // R2
    '{mk(M6,2'd0,1,1,0,0,0,0,4'h0), 8'h21, 1,1, 4'b0001, 1,1, 4'd10}, // R10
    '{mk(M5,2'd1,0,0,0,0,0,0,4'h0), 8'h80, 0,0, 4'b0010, 0,0, 4'd3},  // R3
    '{mk(M5,2'd1,0,0,0,0,0,0,4'h0), 8'h81, 0,0, 4'b0011, 0,0, 4'd3},  // R3
    '{mk(M5,2'd1,1,1,0,0,0,0,4'h0), 8'h01, 0,1, 4'b0001, 0,1, 4'd10}, // R10
    '{mk(MA,2'd2,0,0,0,0,0,0,4'h0), 8'h0B, 0,0, 4'b0001, 1,0, 4'd4},  // R4
    '{mk(MA,2'd2,0,0,0,0,0,0,4'h0), 8'h0B, 0,1, 4'b0001, 1,1, 4'd4},  // R4
    '{mk(MA,2'd2,0,0,0,0,0,0,4'h0), 8'h3B, 1,0, 4'b0010, 1,0, 4'd4},  // R4
    '{mk(MA,2'd2,1,0,0,0,0,0,4'h0), 8'h14, 0,0, 4'b1001, 0,0, 4'd5},  // R5
    '{mk(MA,2'd2,1,0,0,0,0,0,4'h0), 8'h3B, 0,0, 4'b0001, 1,1, 4'd5},  // R5
    '{mk(MA,2'd2,1,0,0,0,0,0,4'h0), 8'h3B, 0,1, 4'b0101, 1,1, 4'd5},  // R5
    '{mk(M4,2'd2,0,1,0,0,0,0,4'h0), 8'h00, 0,0, 4'hB,    0,0, 4'd6},  // R6
    '{mk(M4,2'd2,0,1,0,0,0,0,4'h0), 8'h07, 0,0, 4'hA,    1,0, 4'd6},  // R6
    '{mk(M4,2'd2,1,1,0,0,0,0,4'h0), 8'h05, 1,1, 4'h9,    1,1, 4'd6},  // R6
    '{mk(MA,2'd2,0,0,1,1,0,0,4'h0), 8'h0B, 0,0, 4'b0010, 1,0, 4'd7},  // R7
    '{mk(MA,2'd2,1,0,0,0,1,0,4'h0), 8'h14, 0,1, 4'b1001, 0,0, 4'd7},  // R7
    '{mk(M6,2'd3,0,0,0,0,1,1,4'h0), 8'h21, 0,0, 4'b0001, 0,1, 4'd7}   // R7, R2
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load(input cfg_t c);
    @(negedge clk);
    cfg = c; cfg_en = 1'b1;
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    din = 8'hFF; cin1 = 1'b1; cin2 = 1'b0;
    #(CLK_PERIOD*2 + 1);
    // R1: reset state, all-zero config gives zero outputs, carries pass
    chk("R1", {dout, cout1, cout2}, {4'b0000, 1'b1, 1'b0});
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {dout, cout1, cout2}, {4'b0000, 1'b1, 1'b0});

    for (int i = 0; i < NV; i++) begin
      load(VECS[i].c);
      din = VECS[i].d; cin1 = VECS[i].ci1; cin2 = VECS[i].ci2;
      #1;
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), {dout, cout1, cout2},
          {VECS[i].eo, VECS[i].ec1, VECS[i].ec2});
    end

    // R1: config not applied until the capturing edge
    @(negedge clk);
    cfg = mk(M6,2'd0,0,0,0,0,0,0,4'h0); din = 8'h21; cfg_en = 1'b0;
    #1 chk("R1 no-strobe", {dout, cout1, cout2}, {4'b0001, 1'b0, 1'b1});

    // R8: registered outputs on bits 1:0
    load(mk(MA,2'd2,0,0,0,0,0,0,4'b0011));
    din = 8'h0B; cin1 = 1'b0; cin2 = 1'b0;
    @(negedge clk);
    chk("R8 capture", {2'b00, dout}, {2'b00, 4'b0001});
    din = 8'h03;
    #1 chk("R8 hold", {2'b00, dout}, {2'b00, 4'b0001});
    @(negedge clk);
    chk("R8 update", {2'b00, dout}, {2'b00, 4'b0011});

    // R9: clear hits the registered bit only
    load(mk(MA,2'd2,0,0,0,0,0,0,4'b0001));
    din = 8'h03;
    @(negedge clk);
    chk("R9 pre", {2'b00, dout}, {2'b00, 4'b0011});
    sclr = 1'b1;
    @(negedge clk);
    chk("R9 cleared", {2'b00, dout}, {2'b00, 4'b0010});
    sclr = 1'b0;
    @(negedge clk);
    chk("R9 release", {2'b00, dout}, {2'b00, 4'b0011});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule